// File: doc/BRIEF.md
# Flash Bank Access Timing Controller

This block sits between a requester and one bank of a flash array and decides when an array access may begin and how long it lasts. The requester offers an access on a valid/ready port. A request is accepted in the cycle where both `req_valid` and `req_ready` are high. In that same cycle the block raises the array start strobe. The requester must hold `req_valid` and `req_write` steady while `req_ready` is low. A stalled request is never dropped; it waits until the spacing and ordering rules allow it.

A configuration word holds two 5-bit fields. The spacing field sets how many idle hold cycles must pass after an accepted request before the next one may start. Its all-ones value does not mean 31 cycles: it turns overlapping off, so a new access waits until every earlier access has finished. The write-stretch field adds cycles to write accesses only. Reads take a fixed base time. Both fields are sampled when a request is accepted, so rewriting the configuration never alters an access that is already running. A single-bank input makes the block ignore both fields and behave as non-overlapped with no write stretch. Each access ends with a one-cycle `done` pulse, and the pulses come in acceptance order.

Top module: `ftc_bank_timing`

## Requirements
- R1: After reset both fields are all ones, so `cfg_rdata` reads 0x00001F1F, and `req_ready` is high while no access is outstanding.
- R2: A configuration write stores `cfg_wdata[4:0]` as the spacing field and `cfg_wdata[12:8]` as the write-stretch field. `cfg_rdata` returns exactly those bits in the same positions and zero in every other bit.
- R3: With spacing 0, requests held valid are accepted on consecutive cycles, provided the ordering rule of R8 does not stall them.
- R4: With spacing n in 1..30, `req_ready` stays low for exactly n cycles after an accept, when nothing else stalls the request.
- R5: With spacing 31, the next accept happens no earlier than the cycle after the `done` of every earlier access.
- R6: A read accepted in cycle t pulses `done` for one cycle in cycle t+BASE_RD (default 2).
- R7: A write accepted in cycle t pulses `done` in cycle t+BASE_RD+w, where w is the write-stretch value at accept.
- R8: `done` pulses appear one per access, in acceptance order. A request whose end would fall at or before the end of an outstanding access is held with `req_ready` low.
- R9: `arr_strobe` is high only in an accept cycle. A request held valid while stalled is accepted later and is not lost.
- R10: A configuration write changes only the spacing after, and the length of, accesses accepted after it. An access already accepted keeps its spacing and length.
- R11: With `single_bank` high at accept, the access is timed as spacing 31 and write-stretch 0, whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_bank | input | 1 | Ignore both timing fields |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Access may start this cycle |
| req_write | input | 1 | Offered access is a write |
| arr_strobe | output | 1 | Array access starts this cycle |
| arr_write | output | 1 | Starting access is a write |
| done | output | 1 | One access ends this cycle |

## Verification
The bench runs bursts of held-valid reads at spacing 0, 3 and 31. The gaps between accepts are compared, which separates back-to-back issue, counted hold cycles and the non-overlapped mode. A long write followed at once by a read checks the ordering stall and the order of the `done` pulses. Rewriting the spacing or the write-stretch field while an access is in flight shows whether the timing is latched at accept or read live. Running with single-bank mode on over a register that asks for fast timing shows whether both fields are really overridden.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int FLD_W    = 5;
  localparam int PACE_LSB = 0;
  localparam int WWS_LSB  = 8;
  localparam logic [FLD_W-1:0] NO_OVERLAP = '1;

  typedef struct packed {
    logic [FLD_W-1:0] wws;
    logic [FLD_W-1:0] pace;
  } ftc_cfg_t;
endpackage

// File: rtl/ftc_cfg_regs.sv
module ftc_cfg_regs
  import ftc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output ftc_cfg_t    cfg,
  output logic [31:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.pace <= '1;
      cfg.wws  <= '1;
    end else if (we) begin
      cfg.pace <= wdata[PACE_LSB +: FLD_W];
      cfg.wws  <= wdata[WWS_LSB +: FLD_W];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[PACE_LSB +: FLD_W] = cfg.pace;
    rdata[WWS_LSB +: FLD_W]  = cfg.wws;
  end
endmodule

// File: rtl/ftc_pacer.sv
module ftc_pacer
  import ftc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FLD_W-1:0] pace,
  output logic             gap_open,
  output logic             no_overlap
);
  logic [FLD_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= '0;
      no_overlap <= 1'b1;
    end else if (start) begin
      no_overlap <= (pace == NO_OVERLAP);
      gap_q      <= (pace == NO_OVERLAP) ? '0 : pace;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign gap_open = (gap_q == '0);
endmodule

// File: rtl/ftc_sched.sv
module ftc_sched #(
  parameter int SCH_W = 33,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             done,
  output logic             empty,
  output logic             order_block
);
  logic [SCH_W-1:0] sched_q;
  logic [SCH_W-1:0] sched_d;

  always_comb begin
    sched_d = sched_q >> 1;
    if (start) sched_d[len - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sched_q <= '0;
    else        sched_q <= sched_d;
  end

  always_comb begin
    order_block = 1'b0;
    for (int i = 0; i < SCH_W; i++) begin
      if (sched_q[i] && (i >= int'(len))) order_block = 1'b1;
    end
  end

  assign done  = sched_q[0];
  assign empty = (sched_q == '0);
endmodule

// File: rtl/ftc_bank_timing.sv
module ftc_bank_timing
  import ftc_pkg::*;
#(
  parameter int BASE_RD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        single_bank,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  output logic        arr_strobe,
  output logic        arr_write,
  output logic        done
);
  localparam int MAX_LEN = BASE_RD + (2**FLD_W) - 1;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  ftc_cfg_t         cfg;
  logic [FLD_W-1:0] pace_eff;
  logic [FLD_W-1:0] wws_eff;
  logic [LEN_W-1:0] len;
  logic             gap_open, no_overlap, sch_empty, order_block, start;

  ftc_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  assign pace_eff = single_bank ? NO_OVERLAP : cfg.pace;
  assign wws_eff  = single_bank ? '0 : cfg.wws;
  assign len      = LEN_W'(BASE_RD) + (req_write ? LEN_W'(wws_eff) : '0);

  ftc_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .start(start), .pace(pace_eff),
    .gap_open(gap_open), .no_overlap(no_overlap)
  );

  ftc_sched #(.SCH_W(MAX_LEN), .LEN_W(LEN_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .done(done), .empty(sch_empty), .order_block(order_block)
  );

  assign req_ready  = gap_open && (!no_overlap || sch_empty) && !order_block;
  assign start      = req_valid && req_ready;
  assign arr_strobe = start;
  assign arr_write  = start && req_write;
endmodule

// File: rtl/ftc_bank_timing_chk.sv
module ftc_bank_timing_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        single_bank,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        req_ready,
  input logic        arr_strobe,
  input logic        done
);
  logic [7:0] outstanding;
  logic       nopipe_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      nopipe_last <= 1'b1;
    end else begin
      outstanding <= outstanding + {7'd0, arr_strobe} - {7'd0, done};
      if (arr_strobe) nopipe_last <= single_bank || (cfg_rdata[4:0] == 5'h1F);
    end
  end

  // R1
  p_reset_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rdata == 32'h0000_1F1F));

  // R2
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & 32'h0000_1F1F)));

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_strobe && !single_bank && cfg_rdata[4:0] != 5'd0) |=> !req_ready);

  // R5 / R11
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_strobe && nopipe_last) |-> (outstanding == 8'd0));

  // R8
  p_done_has_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (outstanding != 8'd0));
endmodule

bind ftc_bank_timing ftc_bank_timing_chk chk_i (
  .clk(clk), .rst_n(rst_n), .single_bank(single_bank), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_ready(req_ready),
  .arr_strobe(arr_strobe), .done(done)
);

// File: tb/ftc_bank_timing_tb_top.sv
module ftc_bank_timing_tb_top;
  localparam int BASE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        single_bank = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        arr_strobe, arr_write, done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int pace_m = 31;
  int wws_m = 31;
  int exp_q[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ftc_bank_timing #(.BASE_RD(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .single_bank(single_bank), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .arr_strobe(arr_strobe),
    .arr_write(arr_write), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cfg_write(input int pace, input int wws);
    cfg_we    = 1'b1;
    cfg_wdata = 32'hFFFF_E0E0 | (pace & 31) | ((wws & 31) << 8);
    @(negedge clk);
    cfg_we = 1'b0;
    pace_m = pace;
    wws_m  = wws;
  endtask

  // Driver: offer one access, hold it until accepted, push its end cycle.
  task automatic issue(input bit wr, output int acc);
    int len;
    req_valid = 1'b1;
    req_write = wr;
    forever begin
      #1;
      if (req_ready) begin
        acc = cyc;
        len = BASE + ((wr && !single_bank) ? wws_m : 0);
        exp_q.push_back(acc + len);
        check(arr_strobe && (arr_write == wr), "R9 strobe on accept", int'(arr_strobe), 1);
        @(negedge clk);
        break;
      end
      check(!arr_strobe, "R9 no strobe while stalled", int'(arr_strobe), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  // Monitor: each done pulse must match the oldest expected end cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R6/R7/R8 done cycle", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int a0, a1, a2, a3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(cfg_rdata == 32'h1F1F, "R1 reset fields", cfg_rdata, 32'h1F1F);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R2
    cfg_write(31, 31);
    check(cfg_rdata == 32'h1F1F, "R2 readback all ones", cfg_rdata, 32'h1F1F);
    cfg_write(5, 3);
    check(cfg_rdata == 32'h0305, "R2 readback mixed", cfg_rdata, 32'h0305);

    // R3 + R6: spacing 0, back-to-back reads
    cfg_write(0, 0);
    issue(0, a0); issue(0, a1); issue(0, a2); issue(0, a3);
    check(a1 == a0 + 1 && a2 == a1 + 1 && a3 == a2 + 1, "R3 back-to-back", a3 - a0, 3);
    repeat (6) @(negedge clk);

    // R4: spacing 3
    cfg_write(3, 0);
    issue(0, a0); issue(0, a1); issue(0, a2);
    check(a1 - a0 == 4, "R4 hold of 3", a1 - a0, 4);
    check(a2 - a1 == 4, "R4 hold of 3 again", a2 - a1, 4);
    repeat (6) @(negedge clk);

    // R7 + R8: long write then read stalls for ordering
    cfg_write(0, 4);
    issue(1, a0); issue(0, a1);
    check(a1 - a0 == 5, "R8 ordering stall", a1 - a0, 5);
    repeat (10) @(negedge clk);

    // R5: no overlap
    cfg_write(31, 0);
    issue(0, a0); issue(0, a1); issue(1, a2);
    check(a1 - a0 == BASE + 1, "R5 wait for done", a1 - a0, BASE + 1);
    check(a2 - a1 == BASE + 1, "R5 wait for done write", a2 - a1, BASE + 1);
    repeat (6) @(negedge clk);

    // R10: spacing rewrite during hold window
    cfg_write(10, 0);
    issue(0, a0);
    cfg_write(0, 0);
    issue(0, a1); issue(0, a2);
    check(a1 - a0 == 11, "R10 old spacing kept", a1 - a0, 11);
    check(a2 - a1 == 1, "R10 new spacing used", a2 - a1, 1);
    repeat (6) @(negedge clk);

    // R10: write-stretch rewrite during a write in flight
    cfg_write(0, 6);
    issue(1, a0);
    cfg_write(0, 0);
    repeat (12) @(negedge clk);

    // R11: single bank overrides a fast register setting
    cfg_write(0, 9);
    single_bank = 1'b1;
    @(negedge clk);
    issue(1, a0); issue(0, a1);
    check(a1 - a0 == BASE + 1, "R11 no overlap in single bank", a1 - a0, BASE + 1);
    repeat (8) @(negedge clk);
    single_bank = 1'b0;

    // R9: a stalled request is still accepted
    cfg_write(20, 0);
    issue(0, a0); issue(0, a1);
    check(a1 - a0 == 21, "R9 stalled request kept", a1 - a0, 21);
    repeat (10) @(negedge clk);

    check(exp_q.size() == 0, "R8 all accesses done", exp_q.size(), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule